// File: doc/BRIEF.md
# Sequence Timeout Watchdog Counter

This block is a 30-bit down-counter that a command sequencer arms with a timeout command. Once it is armed, it decrements by one on every clock cycle and does not depend on the command flow. The host may read the live count at any time. When the count runs out, the block sets a sticky "finished" interrupt flag. If the end-of-sequence status is still low at that moment, it also sets a sticky "error" flag. This lets software tell a sequence that overran its time budget from one that finished in time.

There are two ways the sequencer can stop, and the block treats them differently. When the sequencer stops itself through a command, the counter keeps running. When the host aborts the sequence, the count is cleared at once. A debug halt freezes the counter. The two flags stay set until the host writes a one to clear them.

Top module: `seq_timeout_ctr`

## Requirements
- R1: After reset the count is 0 and both flags are 0.
- R2: A load strobe copies the 30-bit load value into the count on the next clock edge. A load while a count is running restarts it with the new value. Loading 0 leaves the counter idle and sets no flag.
- R3: While the count is nonzero and no load, halt or abort is present, the count drops by exactly one per clock edge.
- R4: On the edge where the count steps from 1 to 0, the finished flag (bit `fin_flag`) becomes 1.
- R5: On that same edge, the error flag becomes 1 only if `seq_done` is 0. If `seq_done` is 1, the error flag is left as it was.
- R6: The sequencer self-stop input `cmd_stop` has no effect on the count or on the flags.
- R7: A host abort forces the count to 0 on the next edge and sets no flag. It takes priority over load and halt.
- R8: While `halt` is 1 and there is no abort, the count holds its value, a load is ignored, and no expiry can occur.
- R9: Both flags are sticky. A one on `clr_fin` or `clr_err` clears the matching flag on the next edge, and this also works during halt. If a set and a clear of the same flag fall on the same edge, the flag ends up set.
- R10: The full 30-bit range is usable: a load of all ones yields count 0x3FFFFFFF, and the count then decrements from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Timeout command strobe |
| load_val | input | 30 | Timeout length in cycles |
| seq_done | input | 1 | Sequence has reached its end |
| host_abort | input | 1 | Host cleared the enable to abort |
| cmd_stop | input | 1 | Sequencer stopped itself by command |
| halt | input | 1 | Debug freeze |
| clr_fin | input | 1 | Write-one-to-clear for finished flag |
| clr_err | input | 1 | Write-one-to-clear for error flag |
| count | output | 30 | Live remaining count |
| fin_flag | output | 1 | Sticky timeout-finished flag |
| err_flag | output | 1 | Sticky timeout-error flag |

## Verification
The assertions check on every cycle that the count changes only in the permitted ways: a step of exactly one, a freeze under halt, a clear on abort, and a jump only after a load. They also check that each flag rises only on a genuine 1-to-0 expiry, and the error flag only when the sequence had not finished. The bench scenarios are needed to show the things a single-cycle property cannot: that the expiry lands exactly N cycles after a load of N for every small N, that a self-stop leaves a running count alone, that the flags stay set over long idle periods, and that set wins over clear.

// File: rtl/seq_timeout_ctr.sv
module seq_timeout_ctr #(
  parameter int CW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          seq_done,
  input  logic          host_abort,
  input  logic          cmd_stop,
  input  logic          halt,
  input  logic          clr_fin,
  input  logic          clr_err,
  output logic [CW-1:0] count,
  output logic          fin_flag,
  output logic          err_flag
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          step;
  logic          expire;
  logic [CW-1:0] cnt_nxt;
  logic          unused_stop;

  assign unused_stop = cmd_stop;
  assign step   = !host_abort && !halt && !load && (count != '0);
  assign expire = step && (count == ONE);

  always_comb begin
    if (host_abort)  cnt_nxt = '0;
    else if (halt)   cnt_nxt = count;
    else if (load)   cnt_nxt = load_val;
    else if (step)   cnt_nxt = count - ONE;
    else             cnt_nxt = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      fin_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      count    <= cnt_nxt;
      fin_flag <= (fin_flag && !clr_fin) || expire;
      err_flag <= (err_flag && !clr_err) || (expire && !seq_done);
    end
  end
endmodule

module seq_timeout_ctr_chk #(
  parameter int CW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          seq_done,
  input logic          host_abort,
  input logic          halt,
  input logic [CW-1:0] count,
  input logic          fin_flag,
  input logic          err_flag
);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !load && !halt && !host_abort) |=> count == $past(count) - CW'(1));

  assert_no_jump_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> count <= $past(count));

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_abort |=> count == '0);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !host_abort) |=> $stable(count));

  assert_fin_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_flag) |-> ($past(count) == CW'(1) && count == '0));

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (!$past(seq_done) && $past(count) == CW'(1) && fin_flag));
endmodule

bind seq_timeout_ctr seq_timeout_ctr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .seq_done(seq_done),
  .host_abort(host_abort), .halt(halt), .count(count),
  .fin_flag(fin_flag), .err_flag(err_flag)
);

// File: tb/tb_seq_timeout_ctr.sv
module tb_seq_timeout_ctr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load = 0;
  logic [29:0] load_val = '0;
  logic        seq_done = 0, host_abort = 0, cmd_stop = 0, halt = 0;
  logic        clr_fin = 0, clr_err = 0;
  logic [29:0] count;
  logic        fin_flag, err_flag;

  int total = 0, bad = 0;
  logic [29:0] e_cnt = '0;
  logic        e_fin = 0, e_err = 0;

  always #2 clk = ~clk;

  seq_timeout_ctr dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock edge: update expected state from the requirements, then compare
  task automatic tick(string req);
    logic set_f;
    set_f = 0;
    if (host_abort) e_cnt = '0;                          // R7
    else if (halt) e_cnt = e_cnt;                        // R8
    else if (load) e_cnt = load_val;                     // R2
    else if (e_cnt != 0) begin                           // R3
      if (e_cnt == 1) set_f = 1;                         // R4
      e_cnt = e_cnt - 1;
    end
    e_err = (e_err & ~clr_err) | (set_f & ~seq_done);    // R5 R9
    e_fin = (e_fin & ~clr_fin) | set_f;                  // R9
    @(posedge clk); #1;
    chk(req, {2'b0, count}, {2'b0, e_cnt});
    chk(req, {31'b0, fin_flag}, {31'b0, e_fin});
    chk(req, {31'b0, err_flag}, {31'b0, e_err});
  endtask

  task automatic idle_in();
    load = 0; host_abort = 0; cmd_stop = 0; halt = 0; clr_fin = 0; clr_err = 0;
  endtask

  task automatic clear_all();
    clr_fin = 1; clr_err = 1; tick("R9"); idle_in();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1", {2'b0, count}, 32'd0);
    chk("R1", {30'b0, fin_flag, err_flag}, 32'd0);
    #9; rst_n = 1;
    @(posedge clk); #1;
    chk("R1", {2'b0, count}, 32'd0);

    // R2 R3 R4 R5: sweep lengths and end-status
    for (int n = 0; n <= 10; n++) begin
      for (int d = 0; d < 2; d++) begin
        seq_done = d[0];
        load = 1; load_val = 30'(n); tick("R2"); load = 0;
        for (int k = 0; k < n + 2; k++) tick(d ? "R4" : "R5");
        clear_all();
      end
    end

    // R2 restart while running
    load = 1; load_val = 30'd8; tick("R2");
    load = 0; tick("R3"); tick("R3");
    load = 1; load_val = 30'd3; tick("R2"); load = 0;
    for (int k = 0; k < 5; k++) tick("R2");
    clear_all();

    // R6 self-stop leaves count running
    seq_done = 0;
    load = 1; load_val = 30'd6; tick("R2"); load = 0;
    cmd_stop = 1; tick("R6"); tick("R6"); cmd_stop = 0;
    for (int k = 0; k < 6; k++) tick("R6");
    clear_all();

    // R7 abort with load and halt present
    load = 1; load_val = 30'd9; tick("R2"); load = 0; tick("R3");
    host_abort = 1; load = 1; halt = 1; load_val = 30'd5; tick("R7");
    idle_in();
    for (int k = 0; k < 4; k++) tick("R7");

    // R8 halt freezes and ignores load, no expiry
    load = 1; load_val = 30'd2; tick("R2"); load = 0; tick("R3");
    halt = 1; for (int k = 0; k < 4; k++) tick("R8");
    load = 1; load_val = 30'd20; tick("R8"); load = 0;
    halt = 0; tick("R4"); tick("R4");

    // R9 sticky, clear during halt, set wins over clear
    for (int k = 0; k < 5; k++) tick("R9");
    halt = 1; clr_fin = 1; tick("R9"); clr_fin = 0; halt = 0;
    clr_err = 1; tick("R9"); clr_err = 0;
    seq_done = 0;
    load = 1; load_val = 30'd2; tick("R2"); load = 0;
    tick("R3");
    clr_fin = 1; clr_err = 1; tick("R9"); idle_in();
    tick("R9");
    clear_all();

    // R10 full range
    load = 1; load_val = 30'h3FFFFFFF; tick("R10"); load = 0;
    for (int k = 0; k < 5; k++) tick("R10");
    host_abort = 1; tick("R7"); idle_in();
    tick("R7");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule